// File: doc/BRIEF.md
# Mailbox Shared Interrupt Aggregator

This block gathers the level-sensitive "empty" and "full" indications of up to eight shared mailboxes into one 16-bit status word. It then folds that word onto a small number of shared interrupt lines. Each line has its own 16-bit enable mask. A line is high while any status bit that its mask selects is high. Because the sources are levels, a line stays asserted until the mailbox condition goes away or software clears the mask bit.

Software reaches the block over a plain 32-bit register port: a byte address, a write strobe, write data, and read data that is registered. It can read three things. The first is the combined raw status. The second is a vector showing which shared lines are currently active. The third is a constant word that gives the build-time count of each resource class. After reset every mask is zero, so no line can fire until software sets a mask. The mailboxes that drive the inputs sit outside this block.

Top module: `mbx_irq_agg`

## Requirements
- R1: While the synchronised reset is active, and directly after it, every enable mask is zero, every shared interrupt line is low and the read data is zero.
- R2: The status word at byte offset 0x304 carries the empty level of mailbox k in bit k and its full level in bit 8+k. Each level is the input as sampled at the previous clock edge. Bits for mailboxes beyond NUM_MBOX and bits [31:16] read zero.
- R3: The enable mask of shared line x sits at byte offset 0x100 + 4*x. Bits [15:0] can be written and read back. Bits [31:16] read zero.
- R4: Shared line x is the OR over bits [15:0] of (status AND mask x). It follows an input change one cycle later and stays high for as long as an enabled source stays high.
- R5: A write to the mask of line x changes only line x, and takes effect on the cycle after the write.
- R6: The word at byte offset 0x300 holds the current shared interrupt lines, with line x in bit x. The bits above NUM_SHIRQ read zero.
- R7: The word at byte offset 0x380 is read-only and packs 4-bit counts: mailboxes in [3:0], shared semaphores in [7:4], arbitrated semaphores in [11:8], doorbells in [15:12] and shared lines in [19:16]. Bits [31:20] are zero.
- R8: Writes to 0x300, 0x304 and 0x380, and writes to any unmapped offset, change nothing. A mask slot at or beyond NUM_SHIRQ counts as unmapped. Reads of an unmapped offset return zero.
- R9: Read data shows the register selected by reg_addr at one clock edge from that edge until the next. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mbox_empty | input | NUM_MBOX | Empty level of each mailbox |
| mbox_full | input | NUM_MBOX | Full level of each mailbox |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | NUM_SHIRQ | Shared interrupt lines |

## Verification
The bound checker watches four things on every cycle. Lines stay quiet while the block is in reset. A cycle with no active source gives no interrupt on the next cycle. The vector and dimensioning reads return the live line state and the constant. Unmapped, padding and absent-mailbox bits always read zero. Other properties depend on stimulus, so only the bench scenarios can show them: the exact OR-reduction for every pattern of mailbox levels under different masks, the independence of one line's mask from the others, a line holding high while its source holds, and writes to read-only or unmapped offsets leaving state untouched.

// File: rtl/mbx_irq_agg_pkg.sv
package mbx_irq_agg_pkg;
  // Number of mailbox lanes in the status word (one empty bit and one full bit each)
  localparam int unsigned LANES  = 8;
  localparam int unsigned STAT_W = 2 * LANES;

  // Word addresses (byte offset >> 2) of the register map
  localparam int unsigned ENA_BASE_WORD = 'h040;  // 0x100
  localparam int unsigned VEC_WORD      = 'h0C0;  // 0x300
  localparam int unsigned STAT_WORD     = 'h0C1;  // 0x304
  localparam int unsigned DIM_WORD      = 'h0E0;  // 0x380

  // Packs the five 4-bit resource counts into the read-only description word
  function automatic logic [31:0] dim_word(input int unsigned n_mbox,
                                           input int unsigned n_ssem,
                                           input int unsigned n_asem,
                                           input int unsigned n_dbell,
                                           input int unsigned n_shirq);
    dim_word = {12'h000, 4'(n_shirq), 4'(n_dbell), 4'(n_asem), 4'(n_ssem), 4'(n_mbox)};
  endfunction
endpackage

// File: rtl/mbx_agg_status.sv
module mbx_agg_status
  import mbx_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] empty_i,
  input  logic [NUM_MBOX-1:0] full_i,
  output logic [STAT_W-1:0]   stat_o
);
  logic [LANES-1:0]  empty_pad;
  logic [LANES-1:0]  full_pad;
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] stat_q;

  // Lanes of absent mailboxes stay at zero
  always_comb begin
    empty_pad                 = '0;
    full_pad                  = '0;
    empty_pad[NUM_MBOX-1:0]   = empty_i;
    full_pad[NUM_MBOX-1:0]    = full_i;
    stat_d                    = {full_pad, empty_pad};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/mbx_agg_enables.sv
module mbx_agg_enables
  import mbx_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SHIRQ = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SHIRQ-1:0]        wr_sel_i,
  input  logic [STAT_W-1:0]           wdata_i,
  input  logic [STAT_W-1:0]           stat_i,
  output logic [NUM_SHIRQ*STAT_W-1:0] en_flat_o,
  output logic [NUM_SHIRQ-1:0]        irq_o
);
  for (genvar i = 0; i < NUM_SHIRQ; i++) begin : g_line
    logic [STAT_W-1:0] en_d;
    logic [STAT_W-1:0] en_q;

    always_comb begin
      en_d = en_q;
      if (wr_sel_i[i]) begin
        en_d = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
      end else begin
        en_q <= en_d;
      end
    end

    assign en_flat_o[i*STAT_W +: STAT_W] = en_q;
    assign irq_o[i]                      = |(stat_i & en_q);
  end
endmodule

// File: rtl/mbx_agg_regif.sv
module mbx_agg_regif
  import mbx_irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_SHIRQ = 4,
  parameter logic [31:0] DIM_VALUE = 32'h0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [STAT_W-1:0]           stat_i,
  input  logic [NUM_SHIRQ*STAT_W-1:0] en_flat_i,
  input  logic [NUM_SHIRQ-1:0]        irq_i,
  output logic [NUM_SHIRQ-1:0]        wr_sel_o,
  output logic [31:0]                 rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [NUM_SHIRQ-1:0] ena_hit;
  logic [31:0] rd_d;
  logic [31:0] rd_q;
  logic        addr_unused;

  assign word        = addr_i[ADDR_W-1:2];
  assign addr_unused = ^addr_i[1:0];

  for (genvar i = 0; i < NUM_SHIRQ; i++) begin : g_dec
    assign ena_hit[i]  = (word == WORD_W'(ENA_BASE_WORD + i));
    assign wr_sel_o[i] = we_i & ena_hit[i];
  end

  always_comb begin
    rd_d = '0;
    if (word == WORD_W'(STAT_WORD)) begin
      rd_d = 32'(stat_i);
    end else if (word == WORD_W'(VEC_WORD)) begin
      rd_d = 32'(irq_i);
    end else if (word == WORD_W'(DIM_WORD)) begin
      rd_d = DIM_VALUE;
    end else begin
      for (int i = 0; i < NUM_SHIRQ; i++) begin
        if (ena_hit[i]) begin
          rd_d = 32'(en_flat_i[i*STAT_W +: STAT_W]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mbx_irq_agg.sv
module mbx_irq_agg
  import mbx_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX  = 8,
  parameter int unsigned NUM_SHIRQ = 4,
  parameter int unsigned NUM_SSEM  = 4,
  parameter int unsigned NUM_ASEM  = 4,
  parameter int unsigned NUM_DBELL = 8,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MBOX-1:0]  mbox_empty,
  input  logic [NUM_MBOX-1:0]  mbox_full,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_SHIRQ-1:0] irq
);
  localparam logic [31:0] DIM_VALUE =
    dim_word(NUM_MBOX, NUM_SSEM, NUM_ASEM, NUM_DBELL, NUM_SHIRQ);

  logic [1:0]                  rst_sync_q;
  logic                        rst_act_n;
  logic [STAT_W-1:0]           stat;
  logic [NUM_SHIRQ*STAT_W-1:0] en_flat;
  logic [NUM_SHIRQ-1:0]        wr_sel;
  logic                        wdata_unused;

  assign wdata_unused = ^reg_wdata[31:STAT_W];

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_act_n = rst_sync_q[1];

  mbx_agg_status #(.NUM_MBOX(NUM_MBOX)) u_status (
    .clk     (clk),
    .rst_n   (rst_act_n),
    .empty_i (mbox_empty),
    .full_i  (mbox_full),
    .stat_o  (stat)
  );

  mbx_agg_enables #(.NUM_SHIRQ(NUM_SHIRQ)) u_enables (
    .clk       (clk),
    .rst_n     (rst_act_n),
    .wr_sel_i  (wr_sel),
    .wdata_i   (reg_wdata[STAT_W-1:0]),
    .stat_i    (stat),
    .en_flat_o (en_flat),
    .irq_o     (irq)
  );

  mbx_agg_regif #(
    .ADDR_W    (ADDR_W),
    .NUM_SHIRQ (NUM_SHIRQ),
    .DIM_VALUE (DIM_VALUE)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_act_n),
    .addr_i    (reg_addr),
    .we_i      (reg_we),
    .stat_i    (stat),
    .en_flat_i (en_flat),
    .irq_i     (irq),
    .wr_sel_o  (wr_sel),
    .rdata_o   (reg_rdata)
  );
endmodule

// File: rtl/mbx_irq_agg_chk.sv
module mbx_irq_agg_chk
  import mbx_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX  = 8,
  parameter int unsigned NUM_SHIRQ = 4,
  parameter int unsigned NUM_SSEM  = 4,
  parameter int unsigned NUM_ASEM  = 4,
  parameter int unsigned NUM_DBELL = 8,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_act_n,
  input logic [NUM_MBOX-1:0]  mbox_empty,
  input logic [NUM_MBOX-1:0]  mbox_full,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_rdata,
  input logic [NUM_SHIRQ-1:0] irq
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [7:0]  LMASK  = 8'((1 << NUM_MBOX) - 1);
  localparam logic [31:0] SMASK  = {16'h0000, LMASK, LMASK};
  localparam logic [31:0] DIMV   =
    dim_word(NUM_MBOX, NUM_SSEM, NUM_ASEM, NUM_DBELL, NUM_SHIRQ);

  logic [WORD_W-1:0] w;
  logic              in_ena;
  logic              mapped;

  assign w      = reg_addr[ADDR_W-1:2];
  assign in_ena = (w >= WORD_W'(ENA_BASE_WORD)) &&
                  (w <  WORD_W'(ENA_BASE_WORD + NUM_SHIRQ));
  assign mapped = in_ena || (w == WORD_W'(STAT_WORD)) ||
                  (w == WORD_W'(VEC_WORD)) || (w == WORD_W'(DIM_WORD));

  always @(negedge clk) begin
    if (!rst_act_n) begin
      assert_reset_quiet_R1: assert (irq == '0 && reg_rdata == '0);
    end
  end

  assert_status_pad_R2: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(rst_act_n) && $past(w) == WORD_W'(STAT_WORD)) |-> ((reg_rdata & ~SMASK) == '0));

  assert_enable_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(rst_act_n) && $past(in_ena)) |-> (reg_rdata[31:16] == 16'h0000));

  assert_idle_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_act_n)
    (mbox_empty == '0 && mbox_full == '0) |=> (irq == '0));

  assert_vector_live_R6: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(rst_act_n) && $past(w) == WORD_W'(VEC_WORD)) |-> (reg_rdata == 32'($past(irq))));

  assert_dim_const_R7: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(rst_act_n) && $past(w) == WORD_W'(DIM_WORD)) |-> (reg_rdata == DIMV));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_act_n)
    ($past(rst_act_n) && !$past(mapped)) |-> (reg_rdata == '0));
endmodule

bind mbx_irq_agg mbx_irq_agg_chk #(
  .NUM_MBOX  (NUM_MBOX),
  .NUM_SHIRQ (NUM_SHIRQ),
  .NUM_SSEM  (NUM_SSEM),
  .NUM_ASEM  (NUM_ASEM),
  .NUM_DBELL (NUM_DBELL),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_act_n  (rst_act_n),
  .mbox_empty (mbox_empty),
  .mbox_full  (mbox_full),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .irq        (irq)
);

// File: tb/mbx_irq_agg_test.sv
module mbx_irq_agg_test;
  localparam int unsigned NM = 4;
  localparam int unsigned NS = 3;
  localparam int unsigned SS = 2;
  localparam int unsigned AS = 1;
  localparam int unsigned DB = 5;
  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] mbox_empty;
  logic [NM-1:0] mbox_full;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] en_model [NS];

  always #2 clk = ~clk;

  mbx_irq_agg #(
    .NUM_MBOX(NM), .NUM_SHIRQ(NS), .NUM_SSEM(SS),
    .NUM_ASEM(AS), .NUM_DBELL(DB), .ADDR_W(AW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mbox_empty(mbox_empty), .mbox_full(mbox_full),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [15:0] stat_of(input logic [NM-1:0] e, input logic [NM-1:0] f);
    stat_of = (16'(f) << 8) | 16'(e);
  endfunction

  function automatic logic [NS-1:0] irq_of(input logic [15:0] s);
    for (int i = 0; i < NS; i++) irq_of[i] = |(s & en_model[i]);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual %0d cycles expected fewer", 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] dim_exp;
    logic [15:0] msk [4];
    dim_exp = (32'(NS) << 16) | (32'(DB) << 12) | (32'(AS) << 8) | (32'(SS) << 4) | 32'(NM);
    msk[0] = 16'h0000; msk[1] = 16'h0A05; msk[2] = 16'hFFFF; msk[3] = 16'h0100;
    rst_n = 1'b0; mbox_empty = '0; mbox_full = '0;
    reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    for (int i = 0; i < NS; i++) en_model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "irq during reset", 32'(irq), 32'h0);
    check("R1", "rdata during reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: masks cleared, so sources produce no interrupt
    mbox_empty = '1; mbox_full = '1;
    repeat (2) @(negedge clk);
    check("R1", "irq with all sources and reset masks", 32'(irq), 32'h0);
    for (int i = 0; i < NS; i++) begin
      rd(AW'('h100 + 4*i), d);
      check("R1", "mask after reset", d, 32'h0);
    end
    // R2: all present lanes set, absent lanes and top half zero
    rd(AW'('h304), d);
    check("R2", "status all set", d, 32'h0000_0F0F);
    // R7 and R9: dimension word, address bits [1:0] ignored
    rd(AW'('h380), d);
    check("R7", "dimension word", d, dim_exp);
    rd(AW'('h383), d);
    check("R9", "dimension word with low address bits", d, dim_exp);
    mbox_empty = '0; mbox_full = '0;

    // R3: mask write/readback, upper half reads zero
    wr(AW'('h104), 32'hFFFF_FFFF);
    rd(AW'('h104), d);
    check("R3", "mask readback upper zero", d, 32'h0000_FFFF);
    wr(AW'('h104), 32'h0);

    // R4 / R5 / R6 / R2: sweep all source patterns under several mask sets
    for (int m = 0; m < 4; m++) begin
      en_model[0] = 16'h000F; en_model[1] = 16'h0F00; en_model[2] = msk[m];
      for (int i = 0; i < NS; i++) wr(AW'('h100 + 4*i), 32'(en_model[i]));
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        mbox_empty = NM'(p); mbox_full = NM'(p >> 4);
        @(negedge clk);
        check("R4", "irq for pattern", 32'(irq), 32'(irq_of(stat_of(mbox_empty, mbox_full))));
        if ((p % 37) == 0) begin
          rd(AW'('h304), d);
          check("R2", "status for pattern", d, 32'(stat_of(mbox_empty, mbox_full)));
          rd(AW'('h300), d);
          check("R6", "vector for pattern", d, 32'(irq_of(stat_of(mbox_empty, mbox_full))));
        end
      end
    end

    // R5: changing one mask moves only its own line, the cycle after the write
    mbox_empty = 4'b0010; mbox_full = '0;
    en_model[0] = 16'h0000; en_model[1] = 16'h0000; en_model[2] = 16'h0000;
    for (int i = 0; i < NS; i++) wr(AW'('h100 + 4*i), 32'h0);
    wr(AW'('h104), 32'h0000_0002);
    check("R5", "only line 1 follows its mask", 32'(irq), 32'h2);

    // R4: line holds while its source holds, drops one cycle after release
    mbox_empty = '0; mbox_full = 4'b0010;
    wr(AW'('h100), 32'h0000_0200);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R4", "line holds with level source", 32'(irq[0]), 32'h1);
    end
    mbox_full = '0;
    @(negedge clk);
    check("R4", "line drops after source release", 32'(irq), 32'h0);

    // R8: writes to read-only or unmapped offsets change nothing
    mbox_empty = 4'b1000; mbox_full = 4'b0001;
    en_model[0] = 16'h0008; en_model[1] = 16'h0100; en_model[2] = 16'h0000;
    wr(AW'('h100), 32'h0000_0008);
    wr(AW'('h104), 32'h0000_0100);
    wr(AW'('h108), 32'h0000_0000);
    wr(AW'('h380), 32'h0);
    wr(AW'('h304), 32'h0);
    wr(AW'('h300), 32'hFFFF_FFFF);
    wr(AW'('h10C), 32'hFFFF_FFFF);
    wr(AW'('h000), 32'hFFFF_FFFF);
    check("R8", "irq unchanged after ignored writes", 32'(irq), 32'h3);
    rd(AW'('h380), d);
    check("R8", "dimension unchanged", d, dim_exp);
    rd(AW'('h304), d);
    check("R8", "status follows inputs only", d, 32'h0000_0108);
    for (int i = 0; i < NS; i++) begin
      rd(AW'('h100 + 4*i), d);
      check("R8", "mask unchanged", d, 32'(en_model[i]));
    end
    rd(AW'('h10C), d);
    check("R8", "slot beyond line count reads zero", d, 32'h0);
    rd(AW'('h000), d);
    check("R8", "offset zero reads zero", d, 32'h0);
    rd(AW'('h384), d);
    check("R8", "offset after dimension reads zero", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule